// File: doc/BRIEF.md
# Twin-Predicated Element Loop Sequencer

This block acts as a sub-program-counter for one vectorised instruction. While it runs, the instruction fetch stays on the same instruction. The sequencer walks the elements of the vector one pair at a time. On each handshake it hands the execution datapath a source element index and a destination element index.

Two step counters advance independently, each gated by its own 64-bit predicate mask. Either mask may be complemented. Because the counters are independent, a sparse source can be packed into a dense destination, and the reverse also works. An optional reverse order runs the element indices from the top of the vector down to zero. A data-dependent fail-first mode lets the datapath flag a failing element, which cuts the vector length short at that point.

The vector length and both steps are visible at the ports. While the sequencer is idle, software can load them, so an interrupted loop resumes exactly where it stopped. The block has no register-file access, no ALU and no index remapping.

Top module: `elem_loop_seq`

## Requirements
- R1: After reset the sequencer is idle (`busy`=0), `elem_valid`=0, `done`=0, and the vector length and both steps are 0.
- R2: Each offered pair carries a source index and a destination index. The source index is that of the first enabled source step at or after the source step, and the destination index is that of the first enabled destination step at or after the destination step. After the pair is accepted, each step moves one past the step that was used. Bit e of a mask enables element e, and elements 64 and above are always enabled.
- R3: When `src_inv` or `dst_inv` is 1, the matching mask is complemented before use. This does not apply to elements 64 and above.
- R4: With `reverse`=1, step s names element VL-1-s. The predicate is taken from that element, and that element is the index presented.
- R5: When either counter finds no enabled step below VL, the loop ends. One cycle later `done` is high for exactly one cycle, `busy` falls, and both steps return to 0. With VL=0 no pair is ever offered.
- R6: `go` while idle raises `busy` on the next cycle. `busy` holds the program counter until the loop ends. `go` while busy is ignored.
- R7: While `elem_ready`=0, the offered pair stays the same and neither step moves.
- R8: With `ff_en`=1, an accepted pair that has `elem_fail`=1 ends the loop. VL becomes the destination step of that pair, plus one when `ff_incl`=1. With `ff_en`=0, `elem_fail` has no effect.
- R9: `abort` while busy stops the loop on the next cycle without `done`. The committed steps are kept, and a later `go` continues from them.
- R10: `ctx_wr` while idle loads VL and both steps from `ctx_vl`/`ctx_src`/`ctx_dst`, and the loop then starts from those values. `ctx_wr` while busy is ignored. `ctx_wr` takes precedence over `go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start or resume the element loop |
| abort | input | 1 | Stop the loop and keep the steps (interrupt) |
| ctx_wr | input | 1 | Load the context while idle |
| ctx_vl | input | 7 | Vector length to load |
| ctx_src | input | 7 | Source step to load |
| ctx_dst | input | 7 | Destination step to load |
| src_mask | input | 64 | Source predicate mask |
| dst_mask | input | 64 | Destination predicate mask |
| src_inv | input | 1 | Complement the source mask |
| dst_inv | input | 1 | Complement the destination mask |
| reverse | input | 1 | Run elements high to low |
| ff_en | input | 1 | Enable data-dependent fail-first |
| ff_incl | input | 1 | Keep the failing element in the truncated length |
| elem_ready | input | 1 | Datapath accepts the offered pair |
| elem_fail | input | 1 | The accepted pair failed its test |
| elem_valid | output | 1 | A pair is offered |
| src_idx | output | 7 | Source element index |
| dst_idx | output | 7 | Destination element index |
| busy | output | 1 | Loop running, program counter held |
| done | output | 1 | One-cycle pulse when the loop completes |
| vl_q | output | 7 | Current vector length |
| src_q | output | 7 | Current source step |
| dst_q | output | 7 | Current destination step |

## Verification
The properties assume that the masks, the inversion bits, `reverse` and the fail-first controls stay constant for the whole loop. They also assume that `elem_fail` is only sampled when a pair is accepted. The stimulus changes these controls only while `busy` is low. `elem_ready`, `abort` and `elem_fail` are driven from a single negative-edge process, and `abort` is raised only while the loop is busy. The scoreboard model recomputes the pair order, the truncated length and the resumed steps from the requirement text.

// File: rtl/els_pkg.sv
package els_pkg;
  parameter int unsigned ELS_MAX_VL = 127;
  parameter int unsigned ELS_MASK_W = 64;
  localparam int unsigned ELS_VL_W  = $clog2(ELS_MAX_VL + 1);
  localparam int unsigned ELS_MIX_W = $clog2(ELS_MASK_W);
  localparam int unsigned ELS_LANES = 2;

  typedef logic [ELS_VL_W-1:0]   step_t;
  typedef logic [ELS_MASK_W-1:0] mask_t;

  // element index named by a step, forward or reverse
  function automatic step_t elem_of(step_t step, step_t vl, logic rev);
    return rev ? step_t'(vl - step - step_t'(1)) : step;
  endfunction

  // predicate of one element; lanes past the mask width are always on
  function automatic logic pred_on(mask_t mask, logic inv, step_t e);
    if (int'(e) >= int'(ELS_MASK_W)) return 1'b1;
    return mask[e[ELS_MIX_W-1:0]] ^ inv;
  endfunction

  // next fail-first vector length from the failing destination step
  function automatic step_t ff_len(step_t dstep, logic incl);
    return incl ? step_t'(dstep + step_t'(1)) : dstep;
  endfunction
endpackage

// File: rtl/els_pred_scan.sv
module els_pred_scan
  import els_pkg::*;
(
  input  mask_t mask,
  input  logic  inv,
  input  logic  rev,
  input  step_t vl,
  input  step_t start,
  output step_t next,
  output logic  none
);
  always_comb begin
    next = vl;
    for (int s = int'(ELS_MAX_VL) - 1; s >= 0; s--) begin
      if (step_t'(s) >= start && step_t'(s) < vl &&
          pred_on(mask, inv, elem_of(step_t'(s), vl, rev)))
        next = step_t'(s);
    end
    none = !(next < vl);
  end
endmodule

// File: rtl/els_state.sv
module els_state
  import els_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  go,
  input  logic  abort,
  input  logic  ctx_wr,
  input  step_t ctx_vl,
  input  step_t ctx_src,
  input  step_t ctx_dst,
  input  logic  loop_end,
  input  logic  fire,
  input  logic  fire_fail,
  input  logic  ff_incl,
  input  step_t nxt_src,
  input  step_t nxt_dst,
  output logic  busy,
  output logic  done,
  output step_t vl,
  output step_t src,
  output step_t dst
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      vl   <= '0;
      src  <= '0;
      dst  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (ctx_wr) begin
          vl  <= ctx_vl;
          src <= ctx_src;
          dst <= ctx_dst;
        end else if (go) begin
          busy <= 1'b1;
        end
      end else if (abort) begin
        busy <= 1'b0;
      end else if (loop_end) begin
        busy <= 1'b0;
        done <= 1'b1;
        src  <= '0;
        dst  <= '0;
      end else if (fire) begin
        if (fire_fail) begin
          vl   <= ff_len(nxt_dst, ff_incl);
          busy <= 1'b0;
          done <= 1'b1;
          src  <= '0;
          dst  <= '0;
        end else begin
          src <= step_t'(nxt_src + step_t'(1));
          dst <= step_t'(nxt_dst + step_t'(1));
        end
      end
    end
  end
endmodule

// File: rtl/elem_loop_seq.sv
module elem_loop_seq
  import els_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic        abort,
  input  logic        ctx_wr,
  input  logic [6:0]  ctx_vl,
  input  logic [6:0]  ctx_src,
  input  logic [6:0]  ctx_dst,
  input  logic [63:0] src_mask,
  input  logic [63:0] dst_mask,
  input  logic        src_inv,
  input  logic        dst_inv,
  input  logic        reverse,
  input  logic        ff_en,
  input  logic        ff_incl,
  input  logic        elem_ready,
  input  logic        elem_fail,
  output logic        elem_valid,
  output logic [6:0]  src_idx,
  output logic [6:0]  dst_idx,
  output logic        busy,
  output logic        done,
  output logic [6:0]  vl_q,
  output logic [6:0]  src_q,
  output logic [6:0]  dst_q
);
  mask_t lane_mask  [ELS_LANES];
  logic  lane_inv   [ELS_LANES];
  step_t lane_start [ELS_LANES];
  step_t lane_next  [ELS_LANES];
  logic  lane_none  [ELS_LANES];

  // named internal events
  logic loop_end;
  logic fire;
  logic fire_fail;

  assign lane_mask[0]  = src_mask;
  assign lane_mask[1]  = dst_mask;
  assign lane_inv[0]   = src_inv;
  assign lane_inv[1]   = dst_inv;
  assign lane_start[0] = src_q;
  assign lane_start[1] = dst_q;

  for (genvar g = 0; g < ELS_LANES; g++) begin : g_lane
    els_pred_scan u_scan (
      .mask  (lane_mask[g]),
      .inv   (lane_inv[g]),
      .rev   (reverse),
      .vl    (vl_q),
      .start (lane_start[g]),
      .next  (lane_next[g]),
      .none  (lane_none[g])
    );
  end

  assign loop_end   = busy && !abort && (lane_none[0] || lane_none[1]);
  assign elem_valid = busy && !abort && !lane_none[0] && !lane_none[1];
  assign fire       = elem_valid && elem_ready;
  assign fire_fail  = fire && ff_en && elem_fail;
  assign src_idx    = elem_of(lane_next[0], vl_q, reverse);
  assign dst_idx    = elem_of(lane_next[1], vl_q, reverse);

  els_state u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .abort     (abort),
    .ctx_wr    (ctx_wr),
    .ctx_vl    (ctx_vl),
    .ctx_src   (ctx_src),
    .ctx_dst   (ctx_dst),
    .loop_end  (loop_end),
    .fire      (fire),
    .fire_fail (fire_fail),
    .ff_incl   (ff_incl),
    .nxt_src   (lane_next[0]),
    .nxt_dst   (lane_next[1]),
    .busy      (busy),
    .done      (done),
    .vl        (vl_q),
    .src       (src_q),
    .dst       (dst_q)
  );
endmodule

// File: rtl/els_checker.sv
module els_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       abort,
  input logic       elem_ready,
  input logic       elem_fail,
  input logic       ff_en,
  input logic       elem_valid,
  input logic [6:0] src_idx,
  input logic [6:0] dst_idx,
  input logic       busy,
  input logic       done,
  input logic [6:0] vl_q,
  input logic [6:0] src_q,
  input logic [6:0] dst_q
);
  p_idx_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    elem_valid |-> (src_idx < vl_q) && (dst_idx < vl_q));

  p_done_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && src_q == 7'd0 && dst_q == 7'd0);

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !elem_valid);

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_valid && !elem_ready && !abort) |=> $stable(src_q) && $stable(dst_q));

  p_vl_only_by_fail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(elem_valid && elem_ready && elem_fail && ff_en)) |=> $stable(vl_q));

  p_abort_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && abort) |=> !busy && !done);
endmodule

bind elem_loop_seq els_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .abort      (abort),
  .elem_ready (elem_ready),
  .elem_fail  (elem_fail),
  .ff_en      (ff_en),
  .elem_valid (elem_valid),
  .src_idx    (src_idx),
  .dst_idx    (dst_idx),
  .busy       (busy),
  .done       (done),
  .vl_q       (vl_q),
  .src_q      (src_q),
  .dst_q      (dst_q)
);

// File: tb/sim_elem_loop_seq.sv
module sim_elem_loop_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0, abort = 1'b0, ctx_wr = 1'b0;
  logic [6:0] ctx_vl = '0, ctx_src = '0, ctx_dst = '0;
  logic [63:0] src_mask = '0, dst_mask = '0;
  logic src_inv = 1'b0, dst_inv = 1'b0, reverse = 1'b0, ff_en = 1'b0, ff_incl = 1'b0;
  logic elem_ready = 1'b0, elem_fail = 1'b0;
  logic elem_valid, busy, done;
  logic [6:0] src_idx, dst_idx, vl_q, src_q, dst_q;

  int checks = 0, errors = 0;
  int exp_q[$];
  int ready_mode = 0;
  int fail_k = -1, abort_k = -1, acc_cnt = 0, cyc = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  elem_loop_seq u0 (
    .clk(clk), .rst_n(rst_n), .go(go), .abort(abort), .ctx_wr(ctx_wr),
    .ctx_vl(ctx_vl), .ctx_src(ctx_src), .ctx_dst(ctx_dst),
    .src_mask(src_mask), .dst_mask(dst_mask), .src_inv(src_inv), .dst_inv(dst_inv),
    .reverse(reverse), .ff_en(ff_en), .ff_incl(ff_incl),
    .elem_ready(elem_ready), .elem_fail(elem_fail), .elem_valid(elem_valid),
    .src_idx(src_idx), .dst_idx(dst_idx), .busy(busy), .done(done),
    .vl_q(vl_q), .src_q(src_q), .dst_q(dst_q)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // requirement-level predicate: bit e enables e, e>=64 always on
  function automatic bit en_bit(logic [63:0] m, bit inv, int e);
    if (e > 63) return 1'b1;
    return (m[e] == 1'b1) != inv;
  endfunction

  // monitor / scoreboard: owns ready, abort and fail
  always @(negedge clk) begin
    cyc++;
    case (ready_mode)
      0: elem_ready = 1'b1;
      1: elem_ready = cyc[0];
      2: elem_ready = (cyc % 3) == 0;
      default: elem_ready = 1'b0;
    endcase
    abort = (abort_k >= 0 && acc_cnt == abort_k && busy);
    if (abort) abort_k = -1;
    #1;
    if (elem_valid && elem_ready) begin
      elem_fail = (acc_cnt == fail_k);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected pair", int'(src_idx) * 256 + int'(dst_idx), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(int'(src_idx) * 256 + int'(dst_idx) == e, "R2/R3/R4 pair src*256+dst",
            int'(src_idx) * 256 + int'(dst_idx), e);
      end
      acc_cnt++;
    end else begin
      elem_fail = 1'b0;
    end
  end

  task automatic ctx_load(input int vl, input int s0, input int d0);
    @(negedge clk);
    ctx_wr = 1'b1; ctx_vl = 7'(vl); ctx_src = 7'(s0); ctx_dst = 7'(d0);
    @(negedge clk);
    ctx_wr = 1'b0;
  endtask

  task automatic pulse_go();
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
  endtask

  // driver: computes expected pairs from the requirements and queues them
  task automatic model(input int vl, input int s0, input int d0, input int fk, output int evl);
    int s = s0, d = d0, n = 0;
    evl = vl;
    forever begin
      int sn = s, dn = d;
      while (sn < vl && !en_bit(src_mask, src_inv, reverse ? vl - 1 - sn : sn)) sn++;
      while (dn < vl && !en_bit(dst_mask, dst_inv, reverse ? vl - 1 - dn : dn)) dn++;
      if (sn >= vl || dn >= vl) break;
      exp_q.push_back((reverse ? vl - 1 - sn : sn) * 256 + (reverse ? vl - 1 - dn : dn));
      if (ff_en && n == fk) begin
        evl = ff_incl ? dn + 1 : dn;
        break;
      end
      n++; s = sn + 1; d = dn + 1;
    end
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    chk(done == 1'b1, req, int'(done), 1);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R5 done one cycle, busy low", int'({done, busy}), 0);
  endtask

  task automatic run(input string req, input int vl, input int s0, input int d0,
                     input int fk, input int rmode);
    int evl;
    ctx_load(vl, s0, d0);
    exp_q.delete();
    acc_cnt = 0; fail_k = fk; ready_mode = rmode;
    model(vl, s0, d0, fk, evl);
    pulse_go();
    wait_done(req);
    chk(exp_q.size() == 0, {req, " all pairs issued"}, exp_q.size(), 0);
    chk(vl_q == 7'(evl), {req, " final VL"}, int'(vl_q), evl);
    chk(src_q == 0 && dst_q == 0, "R5 steps cleared", int'(src_q) * 256 + int'(dst_q), 0);
    fail_k = -1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int evl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!busy && !elem_valid && !done, "R1 idle outputs", int'({busy, elem_valid, done}), 0);
    chk(vl_q == 0 && src_q == 0 && dst_q == 0, "R1 state zero", int'(vl_q), 0);

    // R2 dense forward
    src_mask = '1; dst_mask = '1;
    run("R2 dense", 8, 0, 0, -1, 0);
    // R2 compress: sparse source into dense destination
    src_mask = 64'h55;
    run("R2 compress", 8, 0, 0, -1, 0);
    // R3 expand via inverted destination mask
    src_mask = '1; dst_mask = 64'hF0F0; dst_inv = 1'b1;
    run("R3 inverted dst", 16, 0, 0, -1, 0);
    src_mask = 64'h3; src_inv = 1'b1; dst_inv = 1'b0; dst_mask = '1;
    run("R3 inverted src", 6, 0, 0, -1, 1);
    src_inv = 1'b0;
    // R2 elements above 64 always enabled
    src_mask = '0; dst_mask = '1;
    run("R2 high elements", 70, 0, 0, -1, 0);
    // R4 reverse with sparse masks
    reverse = 1'b1; src_mask = 64'b101101; dst_mask = 64'b111011;
    run("R4 reverse", 6, 0, 0, -1, 0);
    reverse = 1'b0;
    // R5 zero length
    src_mask = '1; dst_mask = '1;
    run("R5 VL zero", 0, 0, 0, -1, 0);
    // R7 stalls
    run("R7 stall pattern", 9, 0, 0, -1, 2);
    // R8 fail-first exclude / include / disabled
    ff_en = 1'b1; ff_incl = 1'b0;
    run("R8 fail exclude", 12, 0, 0, 4, 0);
    ff_incl = 1'b1;
    run("R8 fail include", 12, 0, 0, 4, 1);
    ff_incl = 1'b0; dst_mask = 64'hAAA;
    run("R8 fail sparse dst", 12, 0, 0, 2, 0);
    ff_en = 1'b0; dst_mask = '1;
    run("R8 fail ignored", 7, 0, 0, 1, 0);
    // R10 resume from loaded steps
    src_mask = 64'b0101; dst_mask = 64'b0101; dst_inv = 1'b1;
    run("R10 resume mid-loop", 4, 1, 2, -1, 0);
    dst_inv = 1'b0; src_mask = '1; dst_mask = '1;

    // R9 abort then resume
    ctx_load(10, 0, 0);
    exp_q.delete(); acc_cnt = 0; ready_mode = 0;
    model(10, 0, 0, -1, evl);
    abort_k = 3;
    pulse_go();
    begin
      int t = 0;
      bit seen_done = 1'b0;
      while (busy && t < 200) begin @(negedge clk); t++; if (done) seen_done = 1'b1; end
      chk(!busy && !seen_done, "R9 abort stops without done", int'({busy, seen_done}), 0);
    end
    chk(src_q == 3 && dst_q == 3, "R9 steps kept", int'(src_q) * 256 + int'(dst_q), 3 * 256 + 3);
    chk(exp_q.size() == 7, "R9 remaining pairs", exp_q.size(), 7);
    pulse_go();
    wait_done("R9 resumed loop done");
    chk(exp_q.size() == 0, "R9 rest issued", exp_q.size(), 0);

    // R10 ctx write while busy ignored, R6 go while busy ignored, R7 hold
    ctx_load(4, 0, 0);
    exp_q.delete(); acc_cnt = 0; ready_mode = 3;
    model(4, 0, 0, -1, evl);
    pulse_go();
    chk(busy == 1'b1, "R6 busy after go", int'(busy), 1);
    @(negedge clk);
    ctx_wr = 1'b1; ctx_vl = 7'd9; ctx_src = 7'd2; ctx_dst = 7'd2; go = 1'b1;
    @(negedge clk);
    ctx_wr = 1'b0; go = 1'b0;
    chk(vl_q == 4 && src_q == 0 && dst_q == 0, "R10 ctx write ignored while busy", int'(vl_q), 4);
    chk(elem_valid && src_idx == 0 && dst_idx == 0, "R7 pair held while not ready",
        int'(src_idx), 0);
    ready_mode = 0;
    wait_done("R6 loop completes");
    chk(exp_q.size() == 0, "R6 all pairs issued", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule